// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write a 32K x 8 asynchronous static RAM one word at a time. A host raises a request with a write flag, an address and write data. The controller turns that request into registered chip-enable, output-enable and write-enable strobes and a 15-bit address. It returns a single-cycle done pulse, and for a read it returns the captured byte with that pulse. The 8-bit bidirectional data bus is handled through three signals: a data output, an output-enable that a pad or tristate buffer outside the block uses, and a data input.

Every strobe phase is a clock-cycle count. Each count is derived from a nanosecond timing parameter and the clock period: the value is rounded up, and every phase lasts at least one cycle. The write pulse covers the minimum pulse width and the address and chip-enable windows. It is also long enough to wait out the memory's output release and then meet the data setup time. After a read, a turnaround phase keeps the controller off the bus until the memory has released it. A standby input lifts chip enable for data retention. On exit, the controller holds chip enable high for one full read-cycle time before it accepts the next access.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low, ce_n, oe_n and we_n are high, the bus output-enable and done are low, and ready is low. After reset is released, ce_n stays high and ready goes high on the 7th rising edge (ceil(55 ns / 8 ns)).
- R2: When ready is high, ce_n is low, oe_n and we_n are high and the bus is not driven (output-disable mode).
- R3: A write that is accepted on a rising edge gives one setup cycle, then we_n low for 8 cycles (the largest of the pulse, address, chip-enable and cycle windows and the release-plus-setup sum). Done is high in the cycle after the 9th edge that follows acceptance.
- R4: In a write, the bus output-enable rises only after we_n has been low for 4 cycles (25 ns release). It stays high for one cycle after we_n rises and then drops. The write data stays stable throughout, which gives at least 25 ns of setup before we_n rises.
- R5: An accepted read holds oe_n low for 7 cycles. The data input is sampled on the edge that raises oe_n, and done is high with that byte on rdata in the cycle after the 7th edge that follows acceptance.
- R6: After a read, ready stays low for 3 cycles (ceil(20 ns / 8 ns)) once oe_n is high.
- R7: oe_n and we_n are never both low. we_n is low only while ce_n is low. The controller drives the bus only while oe_n is high.
- R8: A request made while ready is low is ignored: no strobe follows and the memory contents are unchanged.
- R9: When the standby input is high in a ready cycle, ce_n goes high on the next edge and ready drops. Standby wins over a request in the same cycle, and that request is dropped.
- R10: After the standby input falls, ce_n stays high and ready stays low until the 8th rising edge. That edge lowers ce_n and raises ready, which gives a 7-cycle recovery after the exit edge.
- R11: The memory address takes the host address on the accepting edge and holds it until done, whatever the host address input does in the meantime.
- R12: Done is high for exactly one cycle for each accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Word address |
| wdata_i | input | 8 | Write data |
| sleep_i | input | 1 | Standby request |
| ready_o | output | 1 | Controller idle and able to accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read data, valid with done_o |
| sram_addr_o | output | 15 | Memory address |
| sram_ce_no | output | 1 | Memory chip enable, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_we_no | output | 1 | Memory write enable, active low |
| sram_dq_o | output | 8 | Data driven toward the memory |
| sram_dq_oe_o | output | 1 | Enables the data pad driver |
| sram_dq_i | input | 8 | Data returned from the memory |

## Verification
Two functions can meet in one idle cycle: entering standby and accepting a request. The bench raises the standby input together with a write request that carries new data. It then checks that chip enable rises on the next edge, that no write-enable pulse appears, and that a read after wake-up still returns the old byte. A second collision is a request that arrives during the read turnaround, when the block is not ready. A behavioural memory model in the bench times every strobe in nanoseconds. It flags any write pulse, address window or data setup that is too short, any bus overlap with the memory's release window, and any read that is sampled before the data is valid.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RD_ACCESS,
    ST_RD_TA,
    ST_SLEEP,
    ST_WAKE
  } ctrl_state_e;

  // ns window -> whole cycles, rounded up, never zero
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned WE_C  = 8,
  parameter int unsigned RD_C  = 7,
  parameter int unsigned OHZ_C = 3,
  parameter int unsigned REC_C = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             sleep_i,
  output ctrl_state_e      state_q_o,
  output ctrl_state_e      state_d_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             accept_o
);

  ctrl_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_i) begin
          state_d = ST_SLEEP;
        end else if (req_i) begin
          accept_o = 1'b1;
          state_d  = we_i ? ST_WR_SETUP : ST_RD_ACCESS;
        end
      end
      ST_WR_SETUP:  state_d = ST_WR_PULSE;
      ST_WR_PULSE:  if (cnt_q == CNT_W'(WE_C - 1))  state_d = ST_WR_HOLD;
      ST_WR_HOLD:   state_d = ST_IDLE;
      ST_RD_ACCESS: if (cnt_q == CNT_W'(RD_C - 1))  state_d = ST_RD_TA;
      ST_RD_TA:     if (cnt_q == CNT_W'(OHZ_C - 1)) state_d = ST_IDLE;
      ST_SLEEP:     if (!sleep_i) state_d = ST_WAKE;
      ST_WAKE:      if (cnt_q == CNT_W'(REC_C - 1)) state_d = ST_IDLE;
      default:      state_d = ST_WAKE;
    endcase
    cnt_d = (state_d != state_q) ? '0 : cnt_q + CNT_W'(1);
  end

  // reset lands in the recovery phase so the first access waits tRC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
  assign cnt_d_o   = cnt_d;

endmodule

// File: rtl/sram_ctrl_strobe.sv
module sram_ctrl_strobe
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned WHZ_C = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_state_e      state_q_i,
  input  ctrl_state_e      state_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             dq_oe_o,
  output logic             done_o
);

  logic ce_n_d, oe_n_d, we_n_d, dq_oe_d, done_d;

  always_comb begin
    ce_n_d  = (state_d_i == ST_SLEEP) || (state_d_i == ST_WAKE);
    oe_n_d  = (state_d_i != ST_RD_ACCESS);
    we_n_d  = (state_d_i != ST_WR_PULSE);
    // drive only after the memory's release window, hold one cycle past WE rise
    dq_oe_d = ((state_d_i == ST_WR_PULSE) && (cnt_d_i >= CNT_W'(WHZ_C))) ||
              (state_d_i == ST_WR_HOLD);
    done_d  = (state_d_i == ST_WR_HOLD) ||
              ((state_d_i == ST_RD_TA) && (state_q_i == ST_RD_ACCESS));
  end

  // all strobes come straight from flops: no decode glitches at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      ce_n_o  <= ce_n_d;
      oe_n_o  <= oe_n_d;
      we_n_o  <= we_n_d;
      dq_oe_o <= dq_oe_d;
      done_o  <= done_d;
    end
  end

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] sram_dq_i,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_addr_o <= '0;
      sram_dq_o   <= '0;
    end else if (accept_i) begin
      sram_addr_o <= addr_i;
      sram_dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= sram_dq_i;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 15,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_WP_NS       = 40,
  parameter int unsigned T_CW_NS       = 50,
  parameter int unsigned T_AW_NS       = 50,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_DS_NS       = 25,
  parameter int unsigned T_WHZ_NS      = 25,
  parameter int unsigned T_OHZ_NS      = 20,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_OE_NS       = 30,
  parameter int unsigned T_RC_NS       = 55
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sleep_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_no,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int unsigned WHZ_C = ns_to_cyc(T_WHZ_NS, CLK_PERIOD_NS);
  localparam int unsigned DS_C  = ns_to_cyc(T_DS_NS, CLK_PERIOD_NS);
  localparam int unsigned WE_C  = umax(umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS), WHZ_C + DS_C),
                                       umax(umax(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS),
                                                 ns_to_cyc(T_CW_NS, CLK_PERIOD_NS)),
                                            ns_to_cyc(T_WC_NS, CLK_PERIOD_NS)));
  localparam int unsigned RD_C  = umax(umax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                            ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)),
                                       ns_to_cyc(T_RC_NS, CLK_PERIOD_NS));
  localparam int unsigned OHZ_C = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_C = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_MAX = umax(umax(WE_C, RD_C), umax(OHZ_C, REC_C));
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);

  ctrl_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             accept, capture;

  sram_ctrl_seq #(
    .CNT_W (CNT_W),
    .WE_C  (WE_C),
    .RD_C  (RD_C),
    .OHZ_C (OHZ_C),
    .REC_C (REC_C)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .sleep_i   (sleep_i),
    .state_q_o (state_q),
    .state_d_o (state_d),
    .cnt_d_o   (cnt_d),
    .accept_o  (accept)
  );

  sram_ctrl_strobe #(
    .CNT_W (CNT_W),
    .WHZ_C (WHZ_C)
  ) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_q_i (state_q),
    .state_d_i (state_d),
    .cnt_d_i   (cnt_d),
    .ce_n_o    (sram_ce_no),
    .oe_n_o    (sram_oe_no),
    .we_n_o    (sram_we_no),
    .dq_oe_o   (sram_dq_oe_o),
    .done_o    (done_o)
  );

  // sample on the edge that raises OE
  assign capture = (state_q == ST_RD_ACCESS) && (state_d == ST_RD_TA);

  sram_ctrl_dpath #(
    .AW (AW),
    .DW (DW)
  ) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .sram_dq_i   (sram_dq_i),
    .sram_addr_o (sram_addr_o),
    .sram_dq_o   (sram_dq_o),
    .rdata_o     (rdata_o)
  );

  assign ready_o = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_o,
  input logic          done_o,
  input logic          sram_ce_no,
  input logic          sram_oe_no,
  input logic          sram_we_no,
  input logic          sram_dq_oe_o,
  input logic [DW-1:0] sram_dq_o,
  input logic [AW-1:0] sram_addr_o
);

  p_idle_outdis_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!sram_ce_no && sram_oe_no && sram_we_no && !sram_dq_oe_o));

  p_oe_we_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_no && !sram_we_no));

  p_we_needs_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no);

  p_drive_oe_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  p_hold_after_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o);

  p_dq_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_standby_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce_no |-> (sram_oe_no && sram_we_no && !sram_dq_oe_o && !ready_o));

  p_addr_hold_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && $past(!sram_we_no)) |-> $stable(sram_addr_o));

  p_addr_hold_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_oe_no && $past(!sram_oe_no)) |-> $stable(sram_addr_o));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .done_o       (done_o),
  .sram_ce_no   (sram_ce_no),
  .sram_oe_no   (sram_oe_no),
  .sram_we_no   (sram_we_no),
  .sram_dq_oe_o (sram_dq_oe_o),
  .sram_dq_o    (sram_dq_o),
  .sram_addr_o  (sram_addr_o)
);

// File: tb/sram_async_ctrl_bench.sv
// one time unit stands for 1 ns; 8-unit period = 125 MHz
module sram_async_ctrl_bench;

  localparam int EXP_REC = 7;  // ceil(55/8)
  localparam int EXP_WE  = 8;  // max(5, 4+4, 7, 7, 7)
  localparam int EXP_WHZ = 4;  // ceil(25/8)
  localparam int EXP_RD  = 7;  // max(7, 4, 7)
  localparam int EXP_OHZ = 3;  // ceil(20/8)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sleep = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, done;
  logic [7:0]  rdata;
  logic [14:0] s_addr;
  logic        s_ce_n, s_oe_n, s_we_n, s_dq_oe;
  logic [7:0]  s_dq_o;
  logic [7:0]  s_dq_i = 8'hEE;

  int n_chk = 0, n_fail = 0, n_overlap = 0;

  always #4 clk = ~clk;

  sram_async_ctrl u_sram_async_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .sleep_i (sleep),
    .ready_o (ready), .done_o (done), .rdata_o (rdata),
    .sram_addr_o (s_addr), .sram_ce_no (s_ce_n), .sram_oe_no (s_oe_n),
    .sram_we_no (s_we_n), .sram_dq_o (s_dq_o), .sram_dq_oe_o (s_dq_oe),
    .sram_dq_i (s_dq_i)
  );

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req_tag, what, act, act, exp, exp);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [7:0] mem_q [32768];
  logic [7:0] ref_q [32768];
  real t_addr = -1000.0, t_ce_fall = -1000.0, t_oe_fall = -1000.0;
  real t_we_fall = -1000.0, t_data = -1000.0, t_hiz = -1000.0;
  logic mem_drive;

  assign mem_drive = !s_ce_n && !s_oe_n && s_we_n;

  always @(s_addr)           t_addr    = $realtime;
  always @(negedge s_ce_n)   t_ce_fall = $realtime;
  always @(negedge s_oe_n)   t_oe_fall = $realtime;
  always @(negedge s_we_n)   t_we_fall = $realtime;
  always @(s_dq_o or posedge s_dq_oe) t_data = $realtime;
  always @(negedge mem_drive) t_hiz = $realtime + 25.0;

  task automatic mem_write_end();
    real now;
    now = $realtime;
    chk(now - t_we_fall >= 40.0, "R3", "model: write pulse ns", int'(now - t_we_fall), 40);
    chk(now - t_addr >= 50.0, "R3", "model: address to end ns", int'(now - t_addr), 50);
    chk(now - t_ce_fall >= 50.0, "R3", "model: ce to end ns", int'(now - t_ce_fall), 50);
    chk(s_dq_oe && (now - t_data >= 25.0), "R4", "model: data setup ns",
        int'(now - t_data), 25);
    mem_q[s_addr] = s_dq_o;
  endtask

  always @(posedge s_we_n) if (!s_ce_n) mem_write_end();
  always @(posedge s_ce_n) if (!s_we_n) mem_write_end();

  initial begin
    forever begin
      #1;
      if (s_dq_oe && (mem_drive || $realtime < t_hiz)) begin
        n_overlap++;
        if (n_overlap == 1) $display("FAIL R7 bus overlap at %0t: actual 1 expected 0", $time);
      end
      if (mem_drive && ($realtime - t_oe_fall >= 30.0) && ($realtime - t_addr >= 55.0)
          && ($realtime - t_ce_fall >= 55.0))
        s_dq_i = mem_q[s_addr];
      else
        s_dq_i = 8'hEE;
    end
  end

  // ---------------- helpers ----------------
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (!ready && guard < 100) begin step(); guard++; end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(s_ce_n && s_oe_n && s_we_n, "R1", "strobes high in reset",
        {s_ce_n, s_oe_n, s_we_n}, 7);
    chk(!s_dq_oe && !done && !ready, "R1", "bus/done/ready low in reset",
        {s_dq_oe, done, ready}, 0);
    rst_n = 1'b1;
    begin
      int n = 0;
      bit ce_ok = 1;
      while (!ready && n < 50) begin
        step();
        n++;
        if (!ready && !s_ce_n) ce_ok = 0;
      end
      chk(n == EXP_REC, "R1", "edges to ready after reset", n, EXP_REC);
      chk(ce_ok, "R1", "ce_n high during recovery", 0, 1);
    end
    chk(!s_ce_n && s_oe_n && s_we_n && !s_dq_oe, "R2", "idle output-disable",
        {s_ce_n, s_oe_n, s_we_n, s_dq_oe}, 6);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    int n = 0, we_low = 0, drv = 0, first_drv = -1;
    bit addr_ok = 1, data_ok = 1;
    wait_ready();
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    step();
    req = 1'b0; addr = ~a; wdata = ~d;
    forever begin
      if (!s_we_n) we_low++;
      if (s_dq_oe) begin
        drv++;
        if (first_drv < 0) first_drv = n;
        if (s_dq_o != d) data_ok = 0;
      end
      if (s_addr != a) addr_ok = 0;
      if (done || n > 40) break;
      step();
      n++;
    end
    chk(n == EXP_WE + 1, "R3", "write latency edges", n, EXP_WE + 1);
    chk(we_low == EXP_WE, "R3", "we_n low cycles", we_low, EXP_WE);
    chk(first_drv == EXP_WHZ + 1, "R4", "first drive cycle", first_drv, EXP_WHZ + 1);
    chk(drv == EXP_WE - EXP_WHZ + 1, "R4", "drive cycles", drv, EXP_WE - EXP_WHZ + 1);
    chk(data_ok, "R4", "driven data", 0, 1);
    chk(addr_ok, "R11", "write address held", 0, 1);
    step();
    chk(!done, "R12", "done one cycle (write)", done, 0);
    chk(!s_dq_oe, "R4", "bus released", s_dq_oe, 0);
    ref_q[a] = d;
  endtask

  task automatic do_read(input logic [14:0] a, input bit poke_busy);
    int n = 0, oe_low = 0, m = 0;
    bit addr_ok = 1, we_quiet = 1;
    wait_ready();
    req = 1'b1; we = 1'b0; addr = a;
    step();
    req = 1'b0; addr = ~a;
    forever begin
      if (!s_oe_n) oe_low++;
      if (s_addr != a) addr_ok = 0;
      if (done || n > 40) break;
      step();
      n++;
    end
    chk(n == EXP_RD, "R5", "read latency edges", n, EXP_RD);
    chk(oe_low == EXP_RD, "R5", "oe_n low cycles", oe_low, EXP_RD);
    chk(rdata == ref_q[a], "R5", "read data", rdata, ref_q[a]);
    chk(addr_ok, "R11", "read address held", 0, 1);
    if (poke_busy) begin
      req = 1'b1; we = 1'b1; addr = a; wdata = ~ref_q[a];
    end
    while (!ready && m < 20) begin
      step();
      m++;
      if (m == 1) chk(!done, "R12", "done one cycle (read)", done, 0);
      if (m == EXP_OHZ - 1) req = 1'b0;
      if (!s_we_n || done) we_quiet = 0;
    end
    req = 1'b0;
    chk(m == EXP_OHZ, "R6", "turnaround cycles", m, EXP_OHZ);
    if (poke_busy) chk(we_quiet, "R8", "busy request ignored", 0, 1);
  endtask

  task automatic t_standby(input logic [14:0] a);
    bit quiet = 1;
    int m = 0;
    bit ce_ok = 1;
    wait_ready();
    sleep = 1'b1; req = 1'b1; we = 1'b1; addr = a; wdata = 8'h77;
    step();
    req = 1'b0;
    chk(s_ce_n && !ready && s_we_n, "R9", "standby entry wins over request",
        {s_ce_n, ready, s_we_n}, 5);
    for (int i = 0; i < 5; i++) begin
      step();
      if (!s_ce_n || !s_we_n || !s_oe_n || done || ready) quiet = 0;
    end
    chk(quiet, "R9", "standby held quiet", 0, 1);
    sleep = 1'b0;
    while (!ready && m < 50) begin
      step();
      m++;
      if (!ready && !s_ce_n) ce_ok = 0;
    end
    chk(m == EXP_REC + 1, "R10", "edges to ready after standby", m, EXP_REC + 1);
    chk(ce_ok, "R10", "ce_n high through recovery", 0, 1);
    chk(!s_ce_n, "R10", "ce_n low when ready", s_ce_n, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    for (int i = 0; i < 32768; i++) begin mem_q[i] = 8'h00; ref_q[i] = 8'h00; end
    t_reset();
    do_write(15'h0000, 8'hA5);
    do_write(15'h7FFF, 8'h5A);
    do_write(15'h1234, 8'h00);
    do_write(15'h4321, 8'hFF);
    do_read(15'h0000, 1'b0);
    do_read(15'h7FFF, 1'b0);
    do_read(15'h1234, 1'b1);   // R8: request during turnaround
    do_read(15'h1234, 1'b0);   // R8: contents unchanged
    do_read(15'h4321, 1'b0);
    do_read(15'h0100, 1'b0);
    do_write(15'h2AAA, 8'h3C);
    do_read(15'h2AAA, 1'b0);   // read right after write
    do_write(15'h2AAA, 8'hC3); // write right after read
    do_read(15'h2AAA, 1'b0);
    t_standby(15'h0000);
    do_read(15'h0000, 1'b0);   // R9: dropped write left old data
    do_write(15'h0555, 8'h81);
    do_read(15'h0555, 1'b0);
    chk(n_overlap == 0, "R7", "bus overlap events", n_overlap, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule